// File: doc/BRIEF.md
# LIN Transmitter Fault Gating Controller

This block decides, cycle by cycle, whether the low-side driver of a single-wire LIN transmitter may pull the bus dominant. It sits between the transmit data line of a LIN protocol controller and the driver-enable of the analog stage. It watches three conditions: an over-temperature flag, a supply under-voltage flag and a low-power-mode flag. While any of them is active it keeps the bus recessive. Recovery from a fault is always timed so that the block never cuts a dominant bit short and never starts one part way through.

A small control/status register holds a two-bit slope-speed select, which is passed to the analog slope shaper, and an interrupt enable for over-temperature. It also shows the live over-temperature condition. An over-temperature event raises an interrupt request. A CPU read of the register clears that request, and a new request needs a fresh onset of the condition.

Top module: `lin_txgate_ctrl`

## Requirements
- R1: While reset is asserted, drv_en is 0, drv_level is 1, irq is 0, slew_mode is 00, and reg_rdata reads 0x00.
- R2: Each of txd_in, ot_in, uv_in and lp_in passes through a two-stage synchronizer, and the driver outputs are registered. A change on txd_in therefore reaches drv_level on the third rising clock edge after the change.
- R3: A synchronized over-temperature condition forces drv_en to 0 on the next edge. Bit 7 of reg_rdata reads 1 for exactly as long as the synchronized condition is present.
- R4: After over-temperature clears, drv_en stays 0 until the synchronized TxD is also 1 (recessive).
- R5: When the enable bit (reg bit 2) is 1, a rising edge of the synchronized over-temperature condition sets irq. A cycle with reg_rd high clears irq, unless a new onset occurs in that same cycle.
- R6: irq is set only by an onset of over-temperature. Holding the condition after an acknowledge, or setting the enable bit while the condition is already present, raises no interrupt. The condition must clear and then return.
- R7: Under-voltage that arrives while TxD is recessive locks the output recessive at once. If it arrives during a dominant phase, that phase goes out in full and the lock takes hold when TxD returns to 1.
- R8: When under-voltage clears, transmission resumes at once if TxD is 1. Otherwise it resumes when TxD next returns to 1.
- R9: While the synchronized low-power flag is 1, drv_en is 0, whatever the other inputs do.
- R10: drv_en is the AND of: no over-temperature lock, no under-voltage lock, and not low-power. drv_level equals the synchronized TxD when enabled, and 1 otherwise.
- R11: The slew select field is reg bits [1:0]: 00 = 20 kbit/s, 01 = 10 kbit/s, 10 = fast 100 kbit/s. Code 11 drives slew_mode as 00, but the raw value reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_in | input | 1 | Transmit data from the protocol controller (1 = recessive) |
| ot_in | input | 1 | Over-temperature flag from the driver |
| uv_in | input | 1 | Supply under-voltage flag |
| lp_in | input | 1 | Low-power mode flag |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acknowledges irq) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: bit 7 status, bit 2 enable, bits 1:0 slew |
| drv_en | output | 1 | Driver enable to the analog stage |
| drv_level | output | 1 | Driven bus level (1 = recessive) |
| slew_mode | output | 2 | Normalized slope-speed select |
| irq | output | 1 | Over-temperature interrupt request |

## Verification
The hardest cases to reach are the ones where a fault starts or ends while TxD is dominant. Under-voltage must then wait for the dominant-to-recessive edge in both directions, and over-temperature must stay locked after the condition clears. Directed sequences hold TxD low across the onset and the removal of each fault, then release it. Random stimulus toggles TxD often and the fault flags seldom, so faults overlap both bus levels and each other. A bench reference model with its own synchronizer delay predicts every output in every cycle.

// File: rtl/lin_txgate_pkg.sv
package lin_txgate_pkg;

  localparam int REG_W     = 8;
  localparam int SLEW_LSB  = 0;
  localparam int SLEW_W    = 2;
  localparam int OTIE_BIT  = 2;
  localparam int OTST_BIT  = 7;

  typedef enum logic [1:0] {
    SLEW_20K  = 2'b00,
    SLEW_10K  = 2'b01,
    SLEW_FAST = 2'b10,
    SLEW_RSVD = 2'b11
  } slew_e;

  // Synchronized input group, packed for the synchronizer bank.
  typedef struct packed {
    logic lp;
    logic uv;
    logic ot;
    logic txd;
  } line_t;

  localparam int    LINE_W   = $bits(line_t);
  localparam line_t LINE_RST = '{lp: 1'b0, uv: 1'b0, ot: 1'b0, txd: 1'b1};

  // The reserved code falls back to the default slope speed.
  function automatic logic [1:0] slew_norm(input logic [1:0] raw);
    return (raw == SLEW_RSVD) ? SLEW_20K : raw;
  endfunction

  // Over-temperature lock: set at once, released only once TxD is recessive.
  function automatic logic ot_lock_nxt(input logic lock, input logic ot, input logic txd);
    if (ot)       return 1'b1;
    else if (txd) return 1'b0;
    else          return lock;
  endfunction

  // Under-voltage lock: may change only while TxD is recessive.
  function automatic logic uv_lock_nxt(input logic lock, input logic uv, input logic txd);
    return txd ? uv : lock;
  endfunction

endpackage

// File: rtl/lin_sync_bank.sv
module lin_sync_bank #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gs] <= RST_VAL;
          else        stage_q[gs] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gs] <= RST_VAL;
          else        stage_q[gs] <= stage_q[gs-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/lin_fault_gate.sv
module lin_fault_gate
  import lin_txgate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ot_s,
  input  logic uv_s,
  input  logic lp_s,
  input  logic txd_s,
  output logic ot_lock,
  output logic uv_lock,
  output logic drv_en,
  output logic drv_level
);

  logic ot_lock_n;
  logic uv_lock_n;
  logic en_n;

  always_comb begin
    ot_lock_n = ot_lock_nxt(ot_lock, ot_s, txd_s);
    uv_lock_n = uv_lock_nxt(uv_lock, uv_s, txd_s);
    en_n      = !ot_lock_n && !uv_lock_n && !lp_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ot_lock   <= 1'b0;
      uv_lock   <= 1'b0;
      drv_en    <= 1'b0;
      drv_level <= 1'b1;
    end else begin
      ot_lock   <= ot_lock_n;
      uv_lock   <= uv_lock_n;
      drv_en    <= en_n;
      drv_level <= en_n ? txd_s : 1'b1;
    end
  end

endmodule

// File: rtl/lin_ctl_regs.sv
module lin_ctl_regs
  import lin_txgate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             ot_s,
  output logic [REG_W-1:0] reg_rdata,
  output logic [1:0]       slew_mode,
  output logic             otie,
  output logic             ot_rise,
  output logic             irq
);

  logic [SLEW_W-1:0] slew_raw;
  logic              ot_prev;

  assign ot_rise   = ot_s && !ot_prev;
  assign slew_mode = slew_norm(slew_raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slew_raw <= SLEW_20K;
      otie     <= 1'b0;
    end else if (reg_wr) begin
      slew_raw <= reg_wdata[SLEW_LSB +: SLEW_W];
      otie     <= reg_wdata[OTIE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ot_prev <= 1'b0;
      irq     <= 1'b0;
    end else begin
      ot_prev <= ot_s;
      if (ot_rise && otie) irq <= 1'b1;
      else if (reg_rd)     irq <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata                        = '0;
    reg_rdata[SLEW_LSB +: SLEW_W]    = slew_raw;
    reg_rdata[OTIE_BIT]              = otie;
    reg_rdata[OTST_BIT]              = ot_s;
  end

endmodule

// File: rtl/lin_txgate_ctrl.sv
module lin_txgate_ctrl
  import lin_txgate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        txd_in,
  input  logic        ot_in,
  input  logic        uv_in,
  input  logic        lp_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        drv_en,
  output logic        drv_level,
  output logic [1:0]  slew_mode,
  output logic        irq
);

  line_t line_raw;
  line_t line_s;
  logic  txd_s, ot_s, uv_s, lp_s;
  logic  ot_lock, uv_lock;
  logic  otie, ot_rise;

  always_comb begin
    line_raw.lp  = lp_in;
    line_raw.uv  = uv_in;
    line_raw.ot  = ot_in;
    line_raw.txd = txd_in;
  end

  lin_sync_bank #(
    .W       (LINE_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (LINE_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_raw),
    .q     (line_s)
  );

  assign txd_s = line_s.txd;
  assign ot_s  = line_s.ot;
  assign uv_s  = line_s.uv;
  assign lp_s  = line_s.lp;

  lin_fault_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .ot_s      (ot_s),
    .uv_s      (uv_s),
    .lp_s      (lp_s),
    .txd_s     (txd_s),
    .ot_lock   (ot_lock),
    .uv_lock   (uv_lock),
    .drv_en    (drv_en),
    .drv_level (drv_level)
  );

  lin_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .ot_s      (ot_s),
    .reg_rdata (reg_rdata),
    .slew_mode (slew_mode),
    .otie      (otie),
    .ot_rise   (ot_rise),
    .irq       (irq)
  );

endmodule

// File: rtl/lin_txgate_chk.sv
module lin_txgate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ot_s,
  input logic       uv_s,
  input logic       lp_s,
  input logic       txd_s,
  input logic       ot_lock,
  input logic       uv_lock,
  input logic       ot_rise,
  input logic       reg_rd,
  input logic       irq,
  input logic       drv_en,
  input logic       drv_level,
  input logic [1:0] slew_mode
);

  assert_ot_forces_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ot_s |=> !drv_en);

  assert_ot_hold_until_recessive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_lock && !txd_s) |=> ot_lock);

  assert_irq_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && reg_rd && !ot_rise) |=> !irq);

  assert_irq_needs_onset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !ot_rise) |=> !irq);

  assert_uv_lock_stable_dominant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_s |=> $stable(uv_lock));

  assert_uv_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_lock && !uv_s && txd_s) |=> !uv_lock);

  assert_lp_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lp_s |=> !drv_en);

  assert_recessive_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> drv_level);

  assert_slew_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    slew_mode != 2'b11);

endmodule

bind lin_txgate_ctrl lin_txgate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ot_s      (ot_s),
  .uv_s      (uv_s),
  .lp_s      (lp_s),
  .txd_s     (txd_s),
  .ot_lock   (ot_lock),
  .uv_lock   (uv_lock),
  .ot_rise   (ot_rise),
  .reg_rd    (reg_rd),
  .irq       (irq),
  .drv_en    (drv_en),
  .drv_level (drv_level),
  .slew_mode (slew_mode)
);

// File: tb/lin_txgate_ctrl_test.sv
`timescale 1ns/1ps
module lin_txgate_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txd_in = 1'b1, ot_in = 1'b0, uv_in = 1'b0, lp_in = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       drv_en, drv_level, irq;
  logic [1:0] slew_mode;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lin_txgate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .ot_in(ot_in), .uv_in(uv_in),
    .lp_in(lp_in), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .drv_en(drv_en), .drv_level(drv_level),
    .slew_mode(slew_mode), .irq(irq)
  );

  // ---------------- reference model ----------------
  // line order: {lp, uv, ot, txd}
  logic [3:0] m1, m2;
  logic m_otl, m_uvl, m_en, m_lvl, m_irq, m_otp, m_otie;
  logic [1:0] m_slew;

  function automatic logic f_ot(input logic lock, input logic ot, input logic txd);
    return ot || (lock && !txd);
  endfunction

  function automatic logic f_uv(input logic lock, input logic uv, input logic txd);
    return (txd && uv) || (!txd && lock);
  endfunction

  function automatic logic [1:0] f_slew(input logic [1:0] s);
    return (s == 2'd3) ? 2'd0 : s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic nol, nuv, ena;
    if (!rst_n) begin
      m1 <= 4'b0001; m2 <= 4'b0001;
      m_otl <= 0; m_uvl <= 0; m_en <= 0; m_lvl <= 1;
      m_irq <= 0; m_otp <= 0; m_otie <= 0; m_slew <= 2'd0;
    end else begin
      nol = f_ot(m_otl, m2[1], m2[0]);
      nuv = f_uv(m_uvl, m2[2], m2[0]);
      ena = !(nol || nuv || m2[3]);
      m1 <= {lp_in, uv_in, ot_in, txd_in};
      m2 <= m1;
      m_otl <= nol; m_uvl <= nuv;
      m_en <= ena;
      m_lvl <= ena ? m2[0] : 1'b1;
      m_otp <= m2[1];
      if (m2[1] && !m_otp && m_otie) m_irq <= 1'b1;
      else if (reg_rd)               m_irq <= 1'b0;
      if (reg_wr) begin
        m_slew <= reg_wdata[1:0];
        m_otie <= reg_wdata[2];
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3 R4 R7 R8 R9 R10 drv_en", {7'b0, drv_en}, {7'b0, m_en});
    check("R2 R10 drv_level", {7'b0, drv_level}, {7'b0, m_lvl});
    check("R5 R6 irq", {7'b0, irq}, {7'b0, m_irq});
    check("R11 slew_mode", {6'b0, slew_mode}, {6'b0, f_slew(m_slew)});
    if (reg_rd)
      check("R3 R11 reg_rdata", reg_rdata, {m2[1], 4'b0, m_otie, m_slew});
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    step(1);
    reg_wr = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 drv_en", {7'b0, drv_en}, 8'h00);
    check("R1 drv_level", {7'b0, drv_level}, 8'h01);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 slew_mode", {6'b0, slew_mode}, 8'h00);
    check("R1 reg_rdata", reg_rdata, 8'h00);
    rst_n = 1'b1;
    step(4);
    check("R10 enabled idle", {7'b0, drv_en}, 8'h01);

    // R2 latency of TxD to drv_level
    txd_in = 1'b0;
    step(2);
    check("R2 not yet", {7'b0, drv_level}, 8'h01);
    step(1);
    check("R2 third edge", {7'b0, drv_level}, 8'h00);

    // R3 / R5: over-temperature while dominant, interrupt enabled
    wr(8'h04);
    ot_in = 1'b1;
    step(4);
    check("R3 ot forces off", {7'b0, drv_en}, 8'h00);
    check("R5 irq set", {7'b0, irq}, 8'h01);
    reg_rd = 1'b1;
    step(1);
    check("R3 status bit", {7'b0, reg_rdata[7]}, 8'h01);
    reg_rd = 1'b0;
    step(1);
    check("R5 irq cleared by read", {7'b0, irq}, 8'h00);
    step(6);
    check("R6 no refire while held", {7'b0, irq}, 8'h00);

    // R4: clear with TxD dominant, then release TxD
    ot_in = 1'b0;
    step(5);
    check("R4 stays off with txd low", {7'b0, drv_en}, 8'h00);
    reg_rd = 1'b1;
    step(1);
    check("R3 status clears", {7'b0, reg_rdata[7]}, 8'h00);
    reg_rd = 1'b0;
    txd_in = 1'b1;
    step(4);
    check("R4 re-enabled", {7'b0, drv_en}, 8'h01);

    // R6: re-arm by a new onset
    ot_in = 1'b1;
    step(4);
    check("R6 rearmed onset fires", {7'b0, irq}, 8'h01);
    reg_rd = 1'b1; step(1); reg_rd = 1'b0;
    wr(8'h00); wr(8'h04);
    step(3);
    check("R6 enable while held no irq", {7'b0, irq}, 8'h00);
    ot_in = 1'b0;
    step(4);

    // R7: under-voltage during a dominant phase
    txd_in = 1'b0;
    step(4);
    uv_in = 1'b1;
    step(4);
    check("R7 dominant not truncated en", {7'b0, drv_en}, 8'h01);
    check("R7 dominant not truncated lvl", {7'b0, drv_level}, 8'h00);
    txd_in = 1'b1;
    step(4);
    check("R7 locked after edge", {7'b0, drv_en}, 8'h00);
    txd_in = 1'b0;
    step(4);
    check("R7 stays recessive", {7'b0, drv_level}, 8'h01);

    // R8: removal while TxD dominant
    uv_in = 1'b0;
    step(4);
    check("R8 waits for recessive", {7'b0, drv_en}, 8'h00);
    txd_in = 1'b1;
    step(4);
    check("R8 resumes", {7'b0, drv_en}, 8'h01);

    // R9: low-power mode
    lp_in = 1'b1; txd_in = 1'b0;
    step(4);
    check("R9 low power off", {7'b0, drv_en}, 8'h00);
    check("R9 low power recessive", {7'b0, drv_level}, 8'h01);
    lp_in = 1'b0; txd_in = 1'b1;
    step(4);

    // R11: slew encoding
    wr(8'h03);
    step(1);
    check("R11 code 11 maps to 00", {6'b0, slew_mode}, 8'h00);
    reg_rd = 1'b1; step(1);
    check("R11 raw readback", {6'b0, reg_rdata[1:0]}, 8'h03);
    reg_rd = 1'b0;
    wr(8'h02);
    step(1);
    check("R11 fast mode", {6'b0, slew_mode}, 8'h02);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(2, 0) == 0)  txd_in = ~txd_in;
      if ($urandom_range(39, 0) == 0) ot_in = ~ot_in;
      if ($urandom_range(39, 0) == 0) uv_in = ~uv_in;
      if ($urandom_range(59, 0) == 0) lp_in = ~lp_in;
      reg_wr    = ($urandom_range(19, 0) == 0);
      reg_wdata = 8'($urandom);
      reg_rd    = ($urandom_range(7, 0) == 0);
      step(1);
    end
    reg_wr = 1'b0; reg_rd = 1'b0;
    step(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule